// File: doc/BRIEF.md
# USB Endpoint Interrupt Priority Router

This block gathers interrupt events from the physical endpoints of a USB device controller and keeps one pending bit for each. There are sixteen logical endpoints, and each has a receive and a transmit direction. A receive endpoint raises its bit when it takes in a packet with no error. A transmit endpoint raises its bit when a packet goes out successfully, or when a NAK handshake is sent while NAK interrupts are enabled. Endpoints marked as isochronous never raise a bit, because their data is serviced on the frame interrupt.

The pending bits are split into a fast group and a slow group by a per-endpoint priority mask. Together with a frame-pending flag, this gives three device-level flags. A small routing register sends the frame flag and the fast flag to either a high-priority or a low-priority request line. Only one of the two may use the high line. If software selects both, both go to the low line. The slow flag always goes to the low line. Software uses a simple register bus to set the priority mask and the routing, to read the pending bits, and to clear them by writing ones.

Top module: `usb_ep_irq_router`

## Requirements
- R1: Pending bit 2n is set by a good receive on endpoint n (`ep_rx_ok[n]`). Pending bit 2n+1 is set by a good transmit on endpoint n (`ep_tx_ok[n]`). The bit is visible in the cycle after the pulse.
- R2: A NAK pulse (`ep_tx_nak[n]`) sets pending bit 2n+1 only while `nak_irq_en` is 1.
- R3: A physical endpoint whose `ep_iso` bit is 1 never sets its pending bit.
- R4: Writing to address 1 clears every pending bit whose data bit is 1. When an event and a clear hit the same bit in the same cycle, the bit stays set.
- R5: The fast flag is the OR of the pending bits whose priority-mask bit (address 2) is 1. The slow flag is the OR of the pending bits whose mask bit is 0. A read of address 4 returns frame pending in bit 0, fast in bit 1 and slow in bit 2.
- R6: The routing register is at address 3. Bit 0 steers the frame flag and bit 1 steers the fast flag. A value of 1 sends the flag to `irq_hp` and a value of 0 sends it to `irq_lp`.
- R7: When both routing bits are 1, neither the frame flag nor the fast flag reaches `irq_hp`, and both drive `irq_lp`.
- R8: The slow flag always drives `irq_lp` and never drives `irq_hp`.
- R9: The routing register is write-only and reads back as 0. A write to the pending-bit address (0) has no effect.
- R10: Reset clears the pending bits, the frame flag, the mask, the routing and both request lines.
- R11: Each request line is registered. It changes one clock after the status or routing change that causes it.
- R12: A `frame_tick` pulse sets the frame flag. Writing a 1 in bit 0 of address 5 clears it, and when a tick and a clear arrive in the same cycle, the tick wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ep_rx_ok | input | 16 | Per-endpoint pulse: packet received without error |
| ep_tx_ok | input | 16 | Per-endpoint pulse: packet transmitted successfully |
| ep_tx_nak | input | 16 | Per-endpoint pulse: NAK sent on an IN endpoint |
| nak_irq_en | input | 1 | Allow NAK pulses to set transmit bits |
| ep_iso | input | 32 | Per physical endpoint: isochronous, never flagged |
| frame_tick | input | 1 | Start-of-frame pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 32 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| irq_hp | output | 1 | High-priority interrupt request |
| irq_lp | output | 1 | Low-priority interrupt request |

## Verification
The assertions assume that the event inputs are single-cycle pulses that are low during reset. They also assume that `ep_iso` and `nak_irq_en` only change between events and never in the same cycle as a pulse they would qualify. The bench changes these configuration inputs only on idle cycles. It drives each event, clear and register write for exactly one clock and then returns every input to zero. One case deliberately pairs an event with a clear of the same bit in a single cycle, and another pairs a frame tick with a frame clear, to reach the collision rules.

// File: rtl/usb_irq_pkg.sv
package usb_irq_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_EP_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EP_CLR   = 3'd1;
  localparam logic [ADDR_W-1:0] A_EP_PRIO  = 3'd2;
  localparam logic [ADDR_W-1:0] A_ROUTE    = 3'd3;
  localparam logic [ADDR_W-1:0] A_DEV_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_DEV_CLR  = 3'd5;

  // device flag positions in the device status word
  localparam int DF_FRAME = 0;
  localparam int DF_FAST  = 1;
  localparam int DF_SLOW  = 2;
  localparam int DF_W     = 3;

  // routing bit positions
  localparam int RT_FRAME = 0;
  localparam int RT_FAST  = 1;
  localparam int RT_W     = 2;
endpackage

// File: rtl/usb_ep_status.sv
module usb_ep_status #(
  parameter int N_EP = 16,
  localparam int PHY = 2 * N_EP
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_EP-1:0] rx_ok,
  input  logic [N_EP-1:0] tx_ok,
  input  logic [N_EP-1:0] tx_nak,
  input  logic           nak_en,
  input  logic [PHY-1:0] iso,
  input  logic           clr_we,
  input  logic [PHY-1:0] clr_mask,
  output logic [PHY-1:0] status
);
  logic [PHY-1:0] set_vec;

  // even bit = receive direction, odd bit = transmit direction
  for (genvar n = 0; n < N_EP; n++) begin : g_ep
    assign set_vec[2*n]   = rx_ok[n] & ~iso[2*n];
    assign set_vec[2*n+1] = (tx_ok[n] | (tx_nak[n] & nak_en)) & ~iso[2*n+1];
  end

  for (genvar b = 0; b < PHY; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        status[b] <= 1'b0;
      else if (set_vec[b])
        status[b] <= 1'b1;          // event beats a simultaneous clear
      else if (clr_we && clr_mask[b])
        status[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/usb_irq_regs.sv
module usb_irq_regs
  import usb_irq_pkg::*;
#(
  parameter int PHY = 32,
  parameter int DW  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [PHY-1:0]    status,
  input  logic [DF_W-1:0]   dev_flags,
  output logic [PHY-1:0]    prio,
  output logic [RT_W-1:0]   route,
  output logic              ep_clr_we,
  output logic              dev_clr_we,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid
);
  logic [DW-1:0] rd_d;
  logic          unused_hi;

  assign unused_hi  = ^wr_data[DW-1:RT_W];
  assign ep_clr_we  = wr_en && (wr_addr == A_EP_CLR);
  assign dev_clr_we = wr_en && (wr_addr == A_DEV_CLR) && wr_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      prio  <= '0;
      route <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_EP_PRIO) prio  <= wr_data[PHY-1:0];
      if (wr_addr == A_ROUTE)   route <= wr_data[RT_W-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    case (rd_addr)
      A_EP_STAT:  rd_d[PHY-1:0]  = status;
      A_EP_PRIO:  rd_d[PHY-1:0]  = prio;
      A_DEV_STAT: rd_d[DF_W-1:0] = dev_flags;
      default:    rd_d = '0;    // routing and clear addresses read as zero
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_d;
    end
  end
endmodule

// File: rtl/usb_irq_route.sv
module usb_irq_route
  import usb_irq_pkg::*;
#(
  parameter int PHY = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PHY-1:0]  status,
  input  logic [PHY-1:0]  prio,
  input  logic [RT_W-1:0] route,
  input  logic            frame_tick,
  input  logic            frame_clr,
  output logic [DF_W-1:0] dev_flags,
  output logic            irq_hp,
  output logic            irq_lp
);
  logic frame_pend, fast, slow;
  logic frame_hi, fast_hi;

  always_ff @(posedge clk) begin
    if (rst)             frame_pend <= 1'b0;
    else if (frame_tick) frame_pend <= 1'b1;
    else if (frame_clr)  frame_pend <= 1'b0;
  end

  assign fast = |(status & prio);
  assign slow = |(status & ~prio);

  // only one source may own the high line; both requested means neither
  assign frame_hi = route[RT_FRAME] & ~route[RT_FAST];
  assign fast_hi  = route[RT_FAST]  & ~route[RT_FRAME];

  always_comb begin
    dev_flags           = '0;
    dev_flags[DF_FRAME] = frame_pend;
    dev_flags[DF_FAST]  = fast;
    dev_flags[DF_SLOW]  = slow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_hp <= 1'b0;
      irq_lp <= 1'b0;
    end else begin
      irq_hp <= (frame_pend & frame_hi) | (fast & fast_hi);
      irq_lp <= slow | (frame_pend & ~frame_hi) | (fast & ~fast_hi);
    end
  end
endmodule

// File: rtl/usb_ep_irq_router.sv
module usb_ep_irq_router
  import usb_irq_pkg::*;
#(
  parameter int N_EP = 16,
  parameter int DW   = 32,
  localparam int PHY = 2 * N_EP
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_EP-1:0]   ep_rx_ok,
  input  logic [N_EP-1:0]   ep_tx_ok,
  input  logic [N_EP-1:0]   ep_tx_nak,
  input  logic              nak_irq_en,
  input  logic [PHY-1:0]    ep_iso,
  input  logic              frame_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              rd_valid,
  output logic              irq_hp,
  output logic              irq_lp
);
  logic [PHY-1:0]  status;
  logic [PHY-1:0]  prio;
  logic [RT_W-1:0] route;
  logic [DF_W-1:0] dev_flags;
  logic            ep_clr_we;
  logic            dev_clr_we;

  usb_ep_status #(.N_EP(N_EP)) u_status (
    .clk      (clk),
    .rst      (rst),
    .rx_ok    (ep_rx_ok),
    .tx_ok    (ep_tx_ok),
    .tx_nak   (ep_tx_nak),
    .nak_en   (nak_irq_en),
    .iso      (ep_iso),
    .clr_we   (ep_clr_we),
    .clr_mask (wr_data[PHY-1:0]),
    .status   (status)
  );

  usb_irq_regs #(.PHY(PHY), .DW(DW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_addr    (rd_addr),
    .status     (status),
    .dev_flags  (dev_flags),
    .prio       (prio),
    .route      (route),
    .ep_clr_we  (ep_clr_we),
    .dev_clr_we (dev_clr_we),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid)
  );

  usb_irq_route #(.PHY(PHY)) u_route (
    .clk        (clk),
    .rst        (rst),
    .status     (status),
    .prio       (prio),
    .route      (route),
    .frame_tick (frame_tick),
    .frame_clr  (dev_clr_we),
    .dev_flags  (dev_flags),
    .irq_hp     (irq_hp),
    .irq_lp     (irq_lp)
  );
endmodule

// File: rtl/usb_irq_router_chk.sv
module usb_irq_router_chk #(
  parameter int N_EP = 16,
  localparam int PHY = 2 * N_EP
) (
  input logic            clk,
  input logic            rst,
  input logic [N_EP-1:0] ep_rx_ok,
  input logic [N_EP-1:0] ep_tx_ok,
  input logic [N_EP-1:0] ep_tx_nak,
  input logic            nak_irq_en,
  input logic [PHY-1:0]  ep_iso,
  input logic            frame_tick,
  input logic [PHY-1:0]  status,
  input logic [PHY-1:0]  prio,
  input logic [1:0]      route,
  input logic [2:0]      dev_flags,
  input logic            irq_hp,
  input logic            irq_lp
);
  logic [PHY-1:0] ev_vec;
  logic [PHY-1:0] iso_only;
  logic           slow_pend;

  for (genvar n = 0; n < N_EP; n++) begin : g_ev
    assign ev_vec[2*n]   = ep_rx_ok[n];
    assign ev_vec[2*n+1] = ep_tx_ok[n] | (ep_tx_nak[n] & nak_irq_en);
  end
  assign iso_only  = ev_vec & ep_iso;
  assign slow_pend = |(status & ~prio);

  // R1 R4: a qualified event always leaves its bit set, even against a clear
  a_r4_event_wins: assert property (@(posedge clk) disable iff (rst)
    (|(ev_vec & ~ep_iso)) |=> ((status & $past(ev_vec & ~ep_iso)) == $past(ev_vec & ~ep_iso)));

  // R3: isochronous endpoints never make a bit rise
  a_r3_iso_quiet: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & $past(iso_only) & ~$past(ev_vec & ~ep_iso)) == '0));

  // R7: both routing bits set keeps the high line quiet
  a_r7_both_no_hp: assert property (@(posedge clk) disable iff (rst)
    (route == 2'b11) |=> !irq_hp);

  // R8: any slow-group bit asserts the low line
  a_r8_slow_lp: assert property (@(posedge clk) disable iff (rst)
    slow_pend |=> irq_lp);

  // R6: frame alone routed high drives the high line
  a_r6_frame_hp: assert property (@(posedge clk) disable iff (rst)
    (route == 2'b01 && dev_flags[0]) |=> irq_hp);

  // R12: a tick always leaves the frame flag set
  a_r12_frame_set: assert property (@(posedge clk) disable iff (rst)
    frame_tick |=> dev_flags[0]);

  // R10: reset state
  a_r10_reset: assert property (@(posedge clk)
    rst |=> (status == '0 && !irq_hp && !irq_lp && route == 2'b00));
endmodule

bind usb_ep_irq_router usb_irq_router_chk #(.N_EP(N_EP)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ep_rx_ok   (ep_rx_ok),
  .ep_tx_ok   (ep_tx_ok),
  .ep_tx_nak  (ep_tx_nak),
  .nak_irq_en (nak_irq_en),
  .ep_iso     (ep_iso),
  .frame_tick (frame_tick),
  .status     (status),
  .prio       (prio),
  .route      (route),
  .dev_flags  (dev_flags),
  .irq_hp     (irq_hp),
  .irq_lp     (irq_lp)
);

// File: tb/sim_usb_ep_irq_router.sv
module sim_usb_ep_irq_router;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ep_rx_ok = '0, ep_tx_ok = '0, ep_tx_nak = '0;
  logic        nak_irq_en = 1'b0;
  logic [31:0] ep_iso = '0;
  logic        frame_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        irq_hp, irq_lp;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  usb_ep_irq_router u0 (.*);

  // monitor: compare read results against the scoreboard
  always @(negedge clk) begin
    if (rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read data %h expected none", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s read got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic pulse(input logic [15:0] rx, input logic [15:0] tx,
                       input logic [15:0] nak, input logic fr);
    ep_rx_ok = rx; ep_tx_ok = tx; ep_tx_nak = nak; frame_tick = fr;
    @(negedge clk);
    ep_rx_ok = '0; ep_tx_ok = '0; ep_tx_nak = '0; frame_tick = 1'b0;
  endtask

  task automatic chk_irq(input logic hp, input logic lp, input string t);
    checks++;
    if (irq_hp !== hp || irq_lp !== lp) begin
      errors++;
      $display("FAIL %s irq hp/lp got %b%b expected %b%b", t, irq_hp, irq_lp, hp, lp);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk_irq(1'b0, 1'b0, "R10");
    rd(3'd0, 32'h0, "R10 status");
    rd(3'd4, 32'h0, "R10 devstat");
    rd(3'd2, 32'h0, "R10 prio");

    // R1 bit mapping
    pulse(16'h0008, 16'h0008, 16'h0, 1'b0);
    pulse(16'h0000, 16'h8000, 16'h0, 1'b0);
    rd(3'd0, 32'h8000_00C0, "R1 mapping");
    // R8 R5: mask zero, all slow
    chk_irq(1'b0, 1'b1, "R8 slow to lp");
    rd(3'd4, 32'h4, "R5 slow flag");

    // R2 NAK gating
    pulse(16'h0, 16'h0, 16'h0020, 1'b0);
    rd(3'd0, 32'h8000_00C0, "R2 nak disabled");
    nak_irq_en = 1'b1;
    @(negedge clk);
    pulse(16'h0, 16'h0, 16'h0020, 1'b0);
    rd(3'd0, 32'h8000_08C0, "R2 nak enabled");
    nak_irq_en = 1'b0;

    // R3 isochronous endpoint ignored
    ep_iso = 32'h0000_0010;
    @(negedge clk);
    pulse(16'h0004, 16'h0, 16'h0, 1'b0);
    rd(3'd0, 32'h8000_08C0, "R3 iso ignored");
    ep_iso = '0;

    // R9 write to status address has no effect
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, 32'h8000_08C0, "R9 status read-only");

    // R4 clear all, then collision
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd0, 32'h0, "R4 clear");
    @(negedge clk);
    chk_irq(1'b0, 1'b0, "R4 idle after clear");
    wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h1; ep_rx_ok = 16'h1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ep_rx_ok = '0;
    rd(3'd0, 32'h1, "R4 event beats clear");

    // R5 R6 fast routed high
    wr(3'd2, 32'h1);
    wr(3'd3, 32'h2);
    @(negedge clk);
    chk_irq(1'b1, 1'b0, "R6 fast to hp");
    rd(3'd4, 32'h2, "R5 fast flag");
    rd(3'd3, 32'h0, "R9 route reads zero");

    // R7 both requested
    wr(3'd3, 32'h3);
    @(negedge clk);
    chk_irq(1'b0, 1'b1, "R7 both to lp");

    // R12 frame flag and routing
    wr(3'd1, 32'h1);
    pulse(16'h0, 16'h0, 16'h0, 1'b1);
    rd(3'd4, 32'h1, "R12 frame set");
    chk_irq(1'b0, 1'b1, "R7 frame lp when both");
    wr(3'd3, 32'h1);
    chk_irq(1'b0, 1'b1, "R11 not yet updated");
    @(negedge clk);
    chk_irq(1'b1, 1'b0, "R11 R6 frame to hp");
    wr(3'd3, 32'h0);
    @(negedge clk);
    chk_irq(1'b0, 1'b1, "R6 frame to lp");
    // tick and clear together
    wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'h1; frame_tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; frame_tick = 1'b0;
    rd(3'd4, 32'h1, "R12 tick beats clear");
    wr(3'd5, 32'h1);
    rd(3'd4, 32'h0, "R12 frame cleared");
    chk_irq(1'b0, 1'b0, "R12 lines idle");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard left %0d expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule